// File: doc/BRIEF.md
# Three-Wire Bus Change Logger

This block watches the data, clock and strobe lines of a three-wire serial synthesizer control bus. The lines are asynchronous to the system clock, so each one is synchronized first. After that, every sampled change on any of them is turned into one printable character.

The character is the ASCII digit '0' to '7'. The digit's value is data plus twice clock plus four times strobe. Characters are queued and sent to a host over an 8N1 UART. From the stream, the host can rebuild the waveform of the bus edge by edge.

A queue of snapshots separates change detection from the slow serial link. When the queue is full, new snapshots are dropped. A sticky flag shows that the record has a gap.

Top module: `bel_logger`

## Requirements
- R1: After reset, tx_o is high and overflow_o is low. The previous-value reference of all three lines is 0, so lines held low through reset produce no character.
- R2: While the synchronized lines keep the same value, no character is sent. Driving a line to the level it already has sends nothing.
- R3: Each character is the byte 0x30 + data + 2*clock + 4*strobe. The line levels used are the new levels after the change.
- R4: Each frame is 8N1. The start bit is low, the eight data bits follow LSB first, and the stop bit is high. Each bit lasts CLK_HZ/BAUD clock cycles, rounded to the nearest cycle. The line is high between frames.
- R5: Characters leave in the same order as the changes that produced them. No character is lost while the queue has room.
- R6: The queue holds FIFO_DEPTH snapshots on top of the one being sent. A snapshot that arrives while the queue is full is dropped, and overflow_o goes high.
- R7: overflow_o stays high until the next reset, whatever the later traffic.
- R8: When several lines change in the same sampled cycle, exactly one character is sent, and it carries all the new levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 1 | Monitored bus data line, asynchronous |
| bus_clk_i | input | 1 | Monitored bus clock line, asynchronous |
| bus_stb_i | input | 1 | Monitored bus strobe line, asynchronous |
| tx_o | output | 1 | UART transmit line, idle high |
| overflow_o | output | 1 | Sticky flag: a snapshot was dropped |

## Verification
Each internal fault shows up at tx_o within one character time.
- A stale previous-value register shows as extra or missing characters after a change.
- A misordered level packing shows as a wrong digit.
- A queue pointer error shows as repeated or skipped digits in the burst that fills the queue.
- A wrong bit counter or divider breaks the stop bit or shifts the later data bits, which a receiver sampling mid-bit detects.

Overflow faults show at overflow_o:
- A missing set shows the cycle after the first dropped snapshot.
- A missing hold shows on any later cycle.

// File: rtl/bel_pkg.sv
package bel_pkg;
  // line order inside a snapshot: {strobe, clock, data}
  typedef logic [2:0] lines_t;

  function automatic logic [7:0] snap_char(input lines_t l);
    return 8'h30 | {5'b00000, l};
  endfunction
endpackage

// File: rtl/bel_sync.sv
module bel_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bel_fifo.sv
module bel_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_q, rd_q;
  logic             do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign pop_data_o = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q[AW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  // R6: a full queue accepts nothing
  a_r6_full_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i) |=> $stable(wr_q));
  // R5: the transmitter never pops an empty queue
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/bel_uart_tx.sv
module bel_uart_tx #(
  parameter int DIV = 434
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       tx_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(DIV - 1);
  localparam logic [3:0]    STOP_BIT  = 4'd9;

  logic          busy_q;
  logic [CW-1:0] baud_q;
  logic [3:0]    bit_q;
  logic [9:0]    sh_q;

  assign pop_o = valid_i && !busy_q;
  assign tx_o  = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      baud_q <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
    end else if (!busy_q) begin
      if (valid_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        busy_q <= 1'b1;
        baud_q <= '0;
        bit_q  <= '0;
      end
    end else if (baud_q == LAST_TICK) begin
      baud_q <= '0;
      sh_q   <= {1'b1, sh_q[9:1]};
      if (bit_q == STOP_BIT) busy_q <= 1'b0;
      else                   bit_q  <= bit_q + 4'd1;
    end else begin
      baud_q <= baud_q + 1'b1;
    end
  end

  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_o);
  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !tx_o);
  a_r4_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_q == STOP_BIT) |-> tx_o);
endmodule

// File: rtl/bel_logger.sv
module bel_logger #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 115_200,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_data_i,
  input  logic bus_clk_i,
  input  logic bus_stb_i,
  output logic tx_o,
  output logic overflow_o
);
  import bel_pkg::*;

  localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;

  lines_t     raw, cur, prev_q;
  logic       change;
  logic [7:0] snap, head;
  logic       empty, full, pop, ovf_q;

  assign raw = {bus_stb_i, bus_clk_i, bus_data_i};

  bel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur;
  end

  assign change = (cur != prev_q);
  assign snap   = snap_char(cur);

  bel_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(change), .push_data_i(snap),
    .pop_i(pop), .pop_data_o(head),
    .empty_o(empty), .full_o(full)
  );

  bel_uart_tx #(.DIV(DIV)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(!empty), .data_i(head),
    .pop_o(pop), .tx_o(tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ovf_q <= 1'b0;
    else if (change && full) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;

  a_r7_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r6_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(full));
  a_r3_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change |-> (snap[7:3] == 5'b00110));
endmodule

// File: tb/test_bel_logger.sv
module test_bel_logger;
  localparam int CLK_HZ = 200_000_000;
  localparam int BAUD   = 25_000_000;
  localparam int DIV    = CLK_HZ / BAUD;  // 8 cycles per bit
  localparam int DEPTH  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic d_r = 1'b0, c_r = 1'b0, s_r = 1'b0;
  logic tx, ovf;

  always #2.5 clk = ~clk;

  bel_logger #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) i_bel_logger (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_data_i(d_r), .bus_clk_i(c_r), .bus_stb_i(s_r),
    .tx_o(tx), .overflow_o(ovf)
  );

  int checks = 0, failures = 0;
  int rx_cnt = 0, frame_err = 0;
  logic [7:0] rx_q [0:255];
  logic [7:0] exp_q [0:255];
  int exp_n = 0;
  logic [2:0] cur_v = 3'd0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic set_lines(input logic [2:0] v, input bit record);
    @(negedge clk);
    {s_r, c_r, d_r} = v;
    if (record && v != cur_v) begin
      exp_q[exp_n] = 8'h30 + {5'd0, v};
      exp_n++;
    end
    cur_v = v;
  endtask

  // host-side receiver, samples mid-bit on falling clock edges
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        logic [7:0] b;
        repeat (DIV / 2 - 1) @(negedge clk);
        if (tx != 1'b0) frame_err++;
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = tx;
        end
        repeat (DIV) @(negedge clk);
        if (tx != 1'b1) frame_err++;
        rx_q[rx_cnt[7:0]] = b;
        rx_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_up();
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    check(tx == 1'b1, "R1 tx idle in reset", tx, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tx == 1'b1, "R1 tx idle after reset", tx, 1);
    check(ovf == 1'b0, "R1 overflow clear", ovf, 0);

    // R2: quiet lines and same-level writes send nothing
    set_lines(3'd0, 1'b1);
    repeat (300) @(negedge clk);
    check(rx_cnt == 0, "R2 no traffic when idle", rx_cnt, 0);

    // R3 R5 R8: every ordered pair of distinct levels, multi-line changes included
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (a != b) begin
          set_lines(a[2:0], 1'b1);
          repeat (100) @(negedge clk);
          set_lines(a[2:0], 1'b1);  // R2: rewrite of same level
          set_lines(b[2:0], 1'b1);
          repeat (100) @(negedge clk);
        end
      end
    end
    repeat (200) @(negedge clk);
    check(rx_cnt == exp_n, "R8 one char per change", rx_cnt, exp_n);
    for (int k = 0; k < exp_n; k++)
      check(rx_q[k] == exp_q[k], "R3 digit value", rx_q[k], exp_q[k]);
    check(frame_err == 0, "R4 start/stop framing", frame_err, 0);
    check(ovf == 1'b0, "R6 no overflow with room", ovf, 0);

    // R6: burst of 20 changes within one char time, 1 + DEPTH survive
    base = rx_cnt;
    exp_n = 0;
    for (int k = 1; k <= 20; k++) begin
      logic [2:0] v;
      v = cur_v + 3'd1;
      set_lines(v, k <= DEPTH + 1);
      repeat (2) @(negedge clk);
    end
    check(ovf == 1'b1, "R6 overflow flagged", ovf, 1);
    repeat ((DEPTH + 2) * (10 * DIV + 2) + 200) @(negedge clk);
    check(rx_cnt - base == DEPTH + 1, "R6 dropped count", rx_cnt - base, DEPTH + 1);
    for (int k = 0; k < DEPTH + 1; k++)
      check(rx_q[(base + k) % 256] == exp_q[k], "R5 burst order", rx_q[(base + k) % 256], exp_q[k]);
    check(frame_err == 0, "R4 back-to-back framing", frame_err, 0);

    // R7: sticky through quiet time and further accepted traffic
    set_lines(3'd0, 1'b0);
    repeat (300) @(negedge clk);
    check(ovf == 1'b1, "R7 overflow sticky", ovf, 1);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ovf == 1'b0, "R1 R7 cleared by reset", ovf, 0);
    check(tx == 1'b1, "R1 tx idle after second reset", tx, 1);
    base = rx_cnt;
    repeat (300) @(negedge clk);
    check(rx_cnt == base, "R1 low lines through reset send nothing", rx_cnt - base, 0);

    set_lines(3'd5, 1'b0);
    repeat (200) @(negedge clk);
    check(rx_cnt == base + 1, "R3 single char after reset", rx_cnt - base, 1);
    check(rx_q[base % 256] == 8'h35, "R3 strobe+data digit", rx_q[base % 256], 8'h35);
    finish_up();
  end
endmodule